// File: doc/BRIEF.md
# Serial Flash Continuous-Read Engine

This block is the host side of a sequential read from a page-organised serial flash. After one start pulse it lowers chip select and sends the continuous-read command byte. It then sends a 24-bit address built from a page number and a byte offset, followed by a run of don't-care padding. From that point it only toggles the clock and gathers the bytes the device returns from consecutive locations. It hands each byte to the fabric on a valid/ready stream and raises chip select once the requested number of bytes has been taken.

Two configuration inputs select the variant for each transfer. The page-size input selects 1056-byte or 1024-byte pages, which changes how the page and the offset are packed into the address. The lane input selects a one-bit serial link or an eight-bit parallel bus, which changes how many padding bytes are sent. The flash clock is a divided copy of the system clock with a low idle level. Outgoing lines change only while that clock is low, and incoming data is captured as it rises. When the consumer stalls, the clock stops, so no byte is ever overwritten.

Top module: `fsr_top`

## Requirements
- R1: After reset, flash_cs_n is 1, flash_sck is 0, busy is 0 and rd_valid is 0.
- R2: Every transfer begins with the command byte 0xE8, followed by three address bytes. Every byte and every address bit is sent most significant bit first.
- R3: With bin_pages=0 (1056-byte pages), the 24-bit address is page_num in bits 23..11 and byte_offset in bits 10..0, i.e. page*2048+offset.
- R4: With bin_pages=1 (1024-byte pages), address bit 23 is 0, page_num occupies bits 22..10 and byte_offset[9:0] occupies bits 9..0, i.e. page*1024+offset.
- R5: After the address, the block sends zero-valued padding: 4 bytes when wide_bus=0 and 19 bytes when wide_bus=1. Data capture starts at the first rising clock edge after the padding. A transfer of N bytes therefore has exactly 64+8N rising edges in serial mode and 23+N in parallel mode.
- R6: With wide_bus=0, one bit moves per clock: out on flash_si, in on flash_so, MSB first. With wide_bus=1, one byte moves per clock on flash_io_out/flash_io_in. flash_io_oe is 1 for every header clock of a parallel transfer and 0 during its data phase.
- R7: flash_sck is low whenever chip select is high. flash_si changes only while flash_sck is low. Input is sampled on the rising edge.
- R8: Exactly byte_count bytes appear on rd_data, in address order. Each byte equals the device contents at start address + k. Chip select then returns high.
- R9: While rd_valid=1 and rd_ready=0, flash_sck and rd_data hold their values.
- R10: busy is 1 from the cycle after an accepted start until chip select returns high. A start that arrives while busy is 1 has no effect.
- R11: A start with byte_offset at or above the page size of the selected mode (1056 or 1024) pulses cfg_err for one cycle and starts no transfer. A start with byte_count=0 also starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a read |
| page_num | input | 13 | Page to read from |
| byte_offset | input | 11 | Starting byte within the page |
| bin_pages | input | 1 | 0: 1056-byte pages, 1: 1024-byte pages |
| wide_bus | input | 1 | 0: one-bit serial link, 1: eight-bit parallel bus |
| byte_count | input | CNT_W | Number of bytes to fetch |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | One-cycle pulse for an out-of-range offset |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Flash clock |
| flash_si | output | 1 | Serial command/address line to the device |
| flash_so | input | 1 | Serial data line from the device |
| flash_io_out | output | 8 | Parallel bus value driven by the host |
| flash_io_oe | output | 1 | Parallel bus drive enable |
| flash_io_in | input | 8 | Parallel bus value from the device |
| rd_data | output | 8 | Fetched byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
The assertions assume three things about the inputs. The consumer may hold rd_ready low for any length of time. The configuration inputs may change at any time. The device returns data from a falling flash clock edge so that it is steady at the next rising edge. The bench's device model drives flash_so and flash_io_in only on falling edges, after the padding count has been reached. The bench moves every input half a system cycle away from the active edge. It changes page_num and pulses start in the middle of a transfer to exercise the busy rule.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam int PAGE_BITS = 13;
  localparam int OFF_BITS  = 11;
  localparam int ADDR_BITS = 24;
  localparam int HDR_FIXED = 4;
  localparam logic [7:0] CMD_CONT_READ = 8'hE8;

  // Number of bytes in one page for the selected page-size mode.
  function automatic logic [OFF_BITS:0] page_bytes(input logic bin_mode);
    return bin_mode ? 12'd1024 : 12'd1056;
  endfunction

  // Pack page and offset into the 24-bit device address.
  function automatic logic [ADDR_BITS-1:0] flash_addr(
      input logic [PAGE_BITS-1:0] page,
      input logic [OFF_BITS-1:0]  off,
      input logic                 bin_mode);
    if (bin_mode)
      return {1'b0, page, off[OFF_BITS-2:0]};
    return {page, off};
  endfunction

  // Byte sent at position idx of the header (command, address, padding).
  function automatic logic [7:0] hdr_byte(input int unsigned idx,
                                          input logic [ADDR_BITS-1:0] a);
    case (idx)
      0:       return CMD_CONT_READ;
      1:       return a[23:16];
      2:       return a[15:8];
      3:       return a[7:0];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fsr_clkgen.sv
module fsr_clkgen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hold,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic          tick;

  assign run      = active && !hold;
  assign tick     = run && (cnt == LAST);
  assign rise_evt = tick && !sck;
  assign fall_evt = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!active) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt <= '0;
        sck <= ~sck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sck); // R7
  AST_SCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold) |=> $stable(sck)); // R9

endmodule

// File: rtl/fsr_launch.sv
module fsr_launch
  import fsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 busy,
  input  logic [OFF_BITS-1:0]  offset,
  input  logic                 bin_mode,
  input  logic                 count_nz,
  output logic                 go,
  output logic                 err
);

  logic in_range;
  logic accept;

  assign in_range = {1'b0, offset} < page_bytes(bin_mode);
  assign accept   = start && !busy;
  assign go       = accept && in_range && count_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= accept && !in_range;
  end

endmodule

// File: rtl/fsr_engine.sv
module fsr_engine
  import fsr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DUMMY_SER = 4,
  parameter int DUMMY_PAR = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 lane_par,
  input  logic [CNT_W-1:0]     count,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 so_bit,
  input  logic [7:0]           io_in,
  input  logic                 data_ready,
  output logic                 active,
  output logic                 hold,
  output logic                 si_bit,
  output logic [7:0]           io_out,
  output logic                 io_oe,
  output logic [7:0]           data_out,
  output logic                 data_valid,
  output logic                 in_data
);

  localparam int HLEN_S = HDR_FIXED + DUMMY_SER;
  localparam int HLEN_P = HDR_FIXED + DUMMY_PAR;
  localparam int HMAX   = (HLEN_S > HLEN_P) ? HLEN_S : HLEN_P;
  localparam int HW     = (HMAX > 1) ? $clog2(HMAX) : 1;
  localparam logic [HW-1:0] LAST_S = HW'(HLEN_S - 1);
  localparam logic [HW-1:0] LAST_P = HW'(HLEN_P - 1);

  logic                 lane_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [HW-1:0]        hdr_idx;
  logic [2:0]           bit_idx;
  logic [CNT_W-1:0]     left;
  logic [6:0]           shreg;
  logic                 vld;

  logic [7:0] cur_byte;
  logic [7:0] cap_byte;
  logic       byte_step;
  logic       hdr_done;
  logic       byte_done;
  logic       finish;

  assign cur_byte  = hdr_byte(int'(hdr_idx), addr_q);
  assign cap_byte  = {shreg, so_bit};
  assign byte_step = lane_q || (bit_idx == 3'd7);
  assign hdr_done  = hdr_idx == (lane_q ? LAST_P : LAST_S);
  assign byte_done = rise_evt && in_data && byte_step;
  assign finish    = fall_evt && in_data && (left == '0);

  assign hold       = vld;
  assign data_valid = vld;
  assign si_bit     = (active && !in_data && !lane_q) ? cur_byte[3'd7 - bit_idx] : 1'b0;
  assign io_out     = (active && !in_data && lane_q) ? cur_byte : 8'h00;
  assign io_oe      = active && !in_data && lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      lane_q   <= 1'b0;
      addr_q   <= '0;
      hdr_idx  <= '0;
      bit_idx  <= '0;
      in_data  <= 1'b0;
      left     <= '0;
      shreg    <= '0;
      data_out <= '0;
      vld      <= 1'b0;
    end else begin
      if (vld && data_ready) vld <= 1'b0;
      if (go) begin
        active  <= 1'b1;
        lane_q  <= lane_par;
        addr_q  <= addr;
        hdr_idx <= '0;
        bit_idx <= '0;
        in_data <= 1'b0;
        left    <= count;
      end else if (active) begin
        if (fall_evt && !in_data) begin
          if (byte_step) begin
            bit_idx <= '0;
            if (hdr_done) in_data <= 1'b1;
            else          hdr_idx <= hdr_idx + 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        if (finish) begin
          active  <= 1'b0;
          in_data <= 1'b0;
        end
        if (rise_evt && in_data) begin
          if (!lane_q) begin
            shreg   <= cap_byte[6:0];
            bit_idx <= bit_idx + 1'b1;
          end
          if (byte_done) begin
            data_out <= lane_q ? io_in : cap_byte;
            vld      <= 1'b1;
            left     <= left - 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !data_ready) |=> (vld && $stable(data_out))); // R9
  AST_DATA_AFTER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> in_data); // R5

endmodule

// File: rtl/fsr_top.sv
module fsr_top
  import fsr_pkg::*;
#(
  parameter int DIV       = 2,
  parameter int CNT_W     = 16,
  parameter int DUMMY_SER = 4,
  parameter int DUMMY_PAR = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PAGE_BITS-1:0] page_num,
  input  logic [OFF_BITS-1:0]  byte_offset,
  input  logic                 bin_pages,
  input  logic                 wide_bus,
  input  logic [CNT_W-1:0]     byte_count,
  output logic                 busy,
  output logic                 cfg_err,
  output logic                 flash_cs_n,
  output logic                 flash_sck,
  output logic                 flash_si,
  input  logic                 flash_so,
  output logic [7:0]           flash_io_out,
  output logic                 flash_io_oe,
  input  logic [7:0]           flash_io_in,
  output logic [7:0]           rd_data,
  output logic                 rd_valid,
  input  logic                 rd_ready
);

  logic go;
  logic active;
  logic hold;
  logic rise_evt;
  logic fall_evt;
  logic in_data;
  logic [ADDR_BITS-1:0] start_addr;

  assign start_addr = flash_addr(page_num, byte_offset, bin_pages);
  assign busy       = active;
  assign flash_cs_n = !active;

  fsr_launch u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (active),
    .offset   (byte_offset),
    .bin_mode (bin_pages),
    .count_nz (byte_count != '0),
    .go       (go),
    .err      (cfg_err)
  );

  fsr_clkgen #(.DIV(DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .hold     (hold),
    .sck      (flash_sck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  fsr_engine #(
    .CNT_W     (CNT_W),
    .DUMMY_SER (DUMMY_SER),
    .DUMMY_PAR (DUMMY_PAR)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .addr       (start_addr),
    .lane_par   (wide_bus),
    .count      (byte_count),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .so_bit     (flash_so),
    .io_in      (flash_io_in),
    .data_ready (rd_ready),
    .active     (active),
    .hold       (hold),
    .si_bit     (flash_si),
    .io_out     (flash_io_out),
    .io_oe      (flash_io_oe),
    .data_out   (rd_data),
    .data_valid (rd_valid),
    .in_data    (in_data)
  );

  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> flash_cs_n); // R11
  AST_SI_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flash_si) |-> !flash_sck); // R7

endmodule

// File: tb/fsr_top_test.sv
module fsr_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] page_num = '0;
  logic [10:0] byte_offset = '0;
  logic        bin_pages = 1'b0;
  logic        wide_bus = 1'b0;
  logic [15:0] byte_count = '0;
  logic        busy, cfg_err, flash_cs_n, flash_sck, flash_si, flash_io_oe, rd_valid;
  logic [7:0]  flash_io_out, rd_data;
  logic        flash_so = 1'b0;
  logic [7:0]  flash_io_in = 8'h00;
  logic        rd_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;
  bit done = 0;

  // device model state
  int          hdr_cnt = 0;
  int          rises = 0;
  int          nout = 0;
  int          cs_falls = 0;
  logic [31:0] hbits = '0;
  bit          dummy_nz = 0;
  bit          oe_bad = 0;
  bit          sck_q = 0;
  bit          cs_q = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsr_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_num(page_num),
    .byte_offset(byte_offset), .bin_pages(bin_pages), .wide_bus(wide_bus),
    .byte_count(byte_count), .busy(busy), .cfg_err(cfg_err),
    .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_si(flash_si),
    .flash_so(flash_so), .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe),
    .flash_io_in(flash_io_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready)
  );

  function automatic logic [7:0] mem(input int a);
    int t;
    t = (a * 29) ^ (a >>> 5);
    return t[7:0];
  endfunction

  // Device model: captures header on rising edges, returns data on falling edges.
  always @(flash_sck or flash_cs_n) begin
    int hl;
    hl = wide_bus ? 23 : 64;
    if (!flash_cs_n && cs_q) begin
      cs_falls++;
      hdr_cnt = 0; rises = 0; nout = 0; hbits = '0; dummy_nz = 0; oe_bad = 0;
    end else if (!flash_cs_n && flash_sck && !sck_q) begin
      rises++;
      if (!wide_bus) begin
        if (hdr_cnt < 64) begin
          if (hdr_cnt < 32) hbits = {hbits[30:0], flash_si};
          else if (flash_si) dummy_nz = 1;
          hdr_cnt++;
        end
      end else begin
        if (hdr_cnt < 23) begin
          if (!flash_io_oe) oe_bad = 1;
          if (hdr_cnt < 4) hbits = {hbits[23:0], flash_io_out};
          else if (flash_io_out != 8'h00) dummy_nz = 1;
          hdr_cnt++;
        end else if (flash_io_oe) oe_bad = 1;
      end
    end else if (!flash_cs_n && !flash_sck && sck_q) begin
      if (hdr_cnt == hl) begin
        if (!wide_bus) begin
          logic [7:0] b;
          b = mem(int'(hbits[23:0]) + nout / 8);
          flash_so = b[7 - (nout % 8)];
        end else begin
          flash_io_in = mem(int'(hbits[23:0]) + nout);
        end
        nout++;
      end
    end
    sck_q = flash_sck;
    cs_q  = flash_cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected=<150000", cyc_total);
      finish_run();
    end
  end

  task automatic do_xfer(input int page, input int off, input bit pm, input bit lane,
                         input int cnt, input int rmode, input bit intrude);
    int exp_addr;
    int got = 0;
    int cyc = 0;
    int falls0;
    bit seen = 0;
    int hold_n = 0;
    bit sck_s = 0;
    logic [7:0] d_s = '0;
    bit r;
    exp_addr = pm ? page * 1024 + off : page * 2048 + off;
    falls0 = cs_falls;
    @(negedge clk);
    page_num = 13'(page); byte_offset = 11'(off); bin_pages = pm; wide_bus = lane;
    byte_count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && flash_cs_n === 1'b0, "R10 busy after start", int'(busy), 1);
    while (busy && cyc < 20000) begin
      case (rmode)
        0: r = 1;
        1: r = (cyc % 3) != 0;
        2: r = (cyc % 7) < 3;
        default: begin
          r = 1;
          if (!seen && rd_valid) begin
            seen = 1; sck_s = flash_sck; d_s = rd_data;
          end
          if (seen && hold_n < 40) begin
            r = 0; hold_n++;
            if (hold_n == 40)
              chk(flash_sck == sck_s && rd_data == d_s && rd_valid,
                  "R9 stall holds clock and data", int'(rd_data), int'(d_s));
          end
        end
      endcase
      if (intrude && cyc == 10) begin start = 1'b1; page_num = ~page_num; end
      else start = 1'b0;
      rd_ready = r;
      if (rd_valid && r) begin
        chk(rd_data == mem(exp_addr + got), "R8 data byte", int'(rd_data), int'(mem(exp_addr + got)));
        got++;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    rd_ready = 1'b0;
    chk(cyc < 20000, "R8 transfer completes", cyc, 20000);
    chk(got == cnt, "R8 byte count", got, cnt);
    chk(hbits[31:24] == 8'hE8, "R2 opcode", int'(hbits[31:24]), 8'hE8);
    chk(int'(hbits[23:0]) == exp_addr, pm ? "R4 address" : "R3 address",
        int'(hbits[23:0]), exp_addr);
    chk(rises == (lane ? 23 + cnt : 64 + 8 * cnt), "R5 clock count", rises,
        lane ? 23 + cnt : 64 + 8 * cnt);
    chk(!dummy_nz, "R5 padding zero", int'(dummy_nz), 0);
    chk(!oe_bad, "R6 bus enable", int'(oe_bad), 0);
    chk(flash_cs_n && !flash_sck, "R7 clock idle low", int'(flash_sck), 0);
    chk(cs_falls == falls0 + 1, "R10 one transaction", cs_falls - falls0, 1);
  endtask

  task automatic try_reject(input int off, input bit pm, input int cnt, input bit want_err);
    int falls0;
    falls0 = cs_falls;
    @(negedge clk);
    byte_offset = 11'(off); bin_pages = pm; byte_count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err === want_err, "R11 error flag", int'(cfg_err), int'(want_err));
    chk(!busy && flash_cs_n, "R11 no transfer", int'(busy), 0);
    @(negedge clk);
    chk(!cfg_err, "R11 error is one pulse", int'(cfg_err), 0);
    repeat (8) @(negedge clk);
    chk(cs_falls == falls0 && !busy, "R11 chip select untouched", cs_falls - falls0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_cs_n === 1'b1 && flash_sck === 1'b0 && busy === 1'b0 && rd_valid === 1'b0,
        "R1 reset state", int'({flash_cs_n, flash_sck, busy, rd_valid}), 8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(flash_cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset",
        int'({flash_cs_n, busy}), 2);

    for (int pm = 0; pm < 2; pm++)
      for (int lane = 0; lane < 2; lane++)
        for (int idx = 0; idx < 3; idx++) begin
          int lim, pg, of;
          lim = pm ? 1024 : 1056;
          pg  = (idx == 0) ? 0 : (idx == 1) ? 8191 : 1234 + pm * 7 + lane;
          of  = (idx == 0) ? 0 : (idx == 1) ? lim - 1 : 517;
          do_xfer(pg, of, pm[0], lane[0], idx + 1, idx, 1'b0);
        end

    // R9 backpressure in both lane modes
    do_xfer(77, 1000, 1'b0, 1'b0, 2, 3, 1'b0);
    do_xfer(4000, 3, 1'b1, 1'b1, 3, 3, 1'b0);
    // R10 start during a transfer is ignored
    do_xfer(321, 12, 1'b0, 1'b0, 3, 0, 1'b1);
    do_xfer(555, 700, 1'b1, 1'b1, 4, 1, 1'b1);
    // R3 offset 1024 is legal in 1056-byte mode
    do_xfer(9, 1024, 1'b0, 1'b1, 2, 0, 1'b0);
    // R11 rejections
    try_reject(1056, 1'b0, 2, 1'b1);
    try_reject(1024, 1'b1, 2, 1'b1);
    try_reject(2047, 1'b0, 1, 1'b1);
    try_reject(5, 1'b0, 0, 1'b0);

    finish_run();
  end

endmodule